// File: doc/BRIEF.md
# Raster and Timer Interrupt Controller

This block gathers the interrupt events of a display controller and turns them into one level-sensitive interrupt request for the processor. There are four event sources. The first is a match between the current raster line and a programmable 9-bit compare line. The other three are underflow pulses from three timers. Each event sets a sticky flag. Software reads the flags, selects which of them may interrupt, and acknowledges a flag by writing a one to its position.

Three byte-wide registers are reached through a small synchronous register port:
- The flag register.
- The mask register. Its bit 0 also serves as bit 8 of the compare line.
- The compare-low register, which holds bits 7..0 of the compare line.

Reads are combinational from the select lines. Writes take effect at the clock edge. The interrupt level is registered. It is computed from the flag and mask values that the edge produces, so every event, write or acknowledge shows on the interrupt pin in the cycle after its edge. The block has no sequencing state. Its behaviour is the register-select decode with four named targets: SEL_FLAGS, SEL_MASK, SEL_LINE and SEL_NONE. Each write is one transition from the current register contents to the next.

Top module: `rline_irq_ctrl`

## Requirements
- R1: After reset, all flags, the mask register and the compare line are zero and `irq` is low.
- R2: `reg_sel` selects a register: 0 = flags, 1 = mask, 2 = compare-low, 3 = none. Writes to select 3 change nothing, and reads of select 3 return 0xFF. In the flag register, bit 1 is the raster flag, bits 3, 4 and 6 are the flags of timers 0, 1 and 2, and bit 7 is the summary bit.
- R3: After every clock edge, `irq` and summary bit 7 are 1 exactly when ((flags | 0x04) & mask & 0x5E) is non-zero, using the register values that edge produced. As a result, mask bit 2 alone requests an interrupt.
- R4: A write to the flag register clears each stored flag whose written bit is 1. An event that sets the same flag in the same cycle wins over the clear.
- R5: A one-cycle pulse on `tmr_uf[i]` sets the flag of timer i at the next edge.
- R6: When `line_start` is high and `raster_line` equals the compare line held before the edge, the raster flag is set.
- R7: The compare line is {mask bit 0, compare-low}. A write that changes the compare line to a value equal to `raster_line` sets the raster flag at that edge. A write that leaves the compare line unchanged does not set it.
- R8: A flags read returns {summary, stored bits 6..0} OR 0x25. A mask read returns the mask OR 0xA0. A compare-low read returns compare-line bits 7..0.
- R9: A write to the mask register changes `irq` in the very next cycle. It raises `irq` for already pending flags and drops it when they become masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| raster_line | input | 9 | Current raster line from the video timing |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| tmr_uf | input | 3 | Underflow pulses of timers 0..2 |
| irq | output | 1 | Interrupt request level, active high |
| rd_data | output | 8 | Read data of the selected register |

## Verification
The bench builds the block with its default parameters: an 8-bit data width, which gives a 9-bit compare line, and three timer sources. These values make every flag position and both forced read patterns observable.

Raster lines are held near 0x120 and compare-low writes are drawn close to that value. This makes write-induced and strobe-induced matches frequent, and it also allows a compare line of 0x0xx or 0x1xx to be selected through mask bit 0. Directed cases cover the following:
- A set and a clear on the same flag in the same edge.
- A rewrite of an unchanged compare line.
- Mask-only forcing through bit 2.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_LINE  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int RASTER_BIT = 1;
    localparam logic [7:0] STORE_MASK = 8'h5A;
    localparam logic [7:0] PEND_MASK  = 8'h5E;
    localparam logic [7:0] FORCE_BIT  = 8'h04;
    localparam logic [7:0] RD_SET_FLG = 8'h25;
    localparam logic [7:0] RD_SET_MSK = 8'hA0;

    function automatic int tmr_pos(input int idx);
        case (idx)
            0:       return 3;
            1:       return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int DW = 8,
    localparam int LW = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wr_data,
    input  logic [LW-1:0] raster_line,
    input  logic          line_start,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] mask_d,
    output logic [LW-1:0] line_q,
    output logic          raster_set
);
    logic [DW-1:0] lo_q, lo_d;
    logic [LW-1:0] line_d;
    logic          hit_wr, hit_strobe;

    always_comb begin
        mask_d = mask_q;
        lo_d   = lo_q;
        if (wr_en) begin
            unique case (sel)
                SEL_FLAGS: ;
                SEL_MASK:  mask_d = wr_data;
                SEL_LINE:  lo_d   = wr_data;
                SEL_NONE:  ;
            endcase
        end
    end

    assign line_q     = {mask_q[0], lo_q};
    assign line_d     = {mask_d[0], lo_d};
    assign hit_wr     = (line_d != line_q) && (line_d == raster_line);
    assign hit_strobe = line_start && (raster_line == line_q);
    assign raster_set = hit_wr || hit_strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            lo_q   <= '0;
        end else begin
            mask_q <= mask_d;
            lo_q   <= lo_d;
        end
    end
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
    import irqc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TMR_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             raster_set,
    input  logic [TMR_N-1:0] tmr_uf,
    output logic [DW-1:0]    flags_q,
    output logic [DW-1:0]    flags_d
);
    logic [DW-1:0] set_vec, clr_vec;
    logic [DW-1:0] tmr_vec [TMR_N+1];

    assign tmr_vec[0] = '0;
    for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
        localparam int POS = tmr_pos(g);
        always_comb begin
            tmr_vec[g+1]      = tmr_vec[g];
            tmr_vec[g+1][POS] = tmr_vec[g][POS] | tmr_uf[g];
        end
    end

    always_comb begin
        set_vec             = tmr_vec[TMR_N];
        set_vec[RASTER_BIT] = raster_set;
        clr_vec             = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_FLAGS: clr_vec = wr_data;
                SEL_MASK:  ;
                SEL_LINE:  ;
                SEL_NONE:  ;
            endcase
        end
        flags_d = ((flags_q & ~clr_vec) | set_vec) & STORE_MASK[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] flags_d,
    input  logic [DW-1:0] mask_d,
    output logic          irq_q
);
    logic pend_d;

    assign pend_d = |((flags_d | FORCE_BIT[DW-1:0]) & mask_d & PEND_MASK[DW-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend_d;
    end
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int DW = 8,
    localparam int LW = DW + 1
) (
    input  reg_sel_e      sel,
    input  logic [DW-1:0] flags_q,
    input  logic          irq_q,
    input  logic [DW-1:0] mask_q,
    input  logic [LW-1:0] line_q,
    output logic [DW-1:0] rd_data
);
    always_comb begin
        unique case (sel)
            SEL_FLAGS: rd_data = {irq_q, flags_q[DW-2:0]} | RD_SET_FLG[DW-1:0];
            SEL_MASK:  rd_data = mask_q | RD_SET_MSK[DW-1:0];
            SEL_LINE:  rd_data = line_q[DW-1:0];
            SEL_NONE:  rd_data = '1;
        endcase
    end
endmodule

// File: rtl/rline_irq_ctrl.sv
module rline_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TMR_N = 3,
    localparam int LW   = DW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [LW-1:0]    raster_line,
    input  logic             line_start,
    input  logic [TMR_N-1:0] tmr_uf,
    output logic             irq,
    output logic [DW-1:0]    rd_data
);
    reg_sel_e      sel;
    logic [DW-1:0] mask_q, mask_d, flags_q, flags_d;
    logic [LW-1:0] cmp_line_q;
    logic          raster_set;

    assign sel = reg_sel_e'(reg_sel);

    irqc_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
        .raster_line(raster_line), .line_start(line_start),
        .mask_q(mask_q), .mask_d(mask_d), .line_q(cmp_line_q), .raster_set(raster_set)
    );

    irqc_flags #(.DW(DW), .TMR_N(TMR_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
        .raster_set(raster_set), .tmr_uf(tmr_uf),
        .flags_q(flags_q), .flags_d(flags_d)
    );

    irqc_pending #(.DW(DW)) u_pend (
        .clk(clk), .rst_n(rst_n), .flags_d(flags_d), .mask_d(mask_d), .irq_q(irq)
    );

    irqc_rdmux #(.DW(DW)) u_rd (
        .sel(sel), .flags_q(flags_q), .irq_q(irq), .mask_q(mask_q),
        .line_q(cmp_line_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_sel,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [8:0] raster_line,
    input logic       line_start,
    input logic [2:0] tmr_uf,
    input logic       irq,
    input logic [7:0] rd_data,
    input logic [7:0] flags_q,
    input logic [7:0] mask_q,
    input logic [8:0] cmp_line_q
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!irq && flags_q == 8'h00 && mask_q == 8'h00));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !line_start && tmr_uf == 3'b000) |=> ($stable(flags_q) && $stable(mask_q)));

    a_r3_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (((flags_q | 8'h04) & mask_q & 8'h5E) != 8'h00));

    a_r4_clear_t0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd0 && wr_data[3] && !tmr_uf[0]) |=> !flags_q[3]);

    a_r5_tmr0_set: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_uf[0] |=> flags_q[3]);

    a_r5_tmr2_set: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_uf[2] |=> flags_q[6]);

    a_r6_line_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && raster_line == cmp_line_q) |=> flags_q[1]);

    a_r8_flag_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd0) |-> (rd_data[0] && rd_data[2] && rd_data[5] && rd_data[7] == irq));
endmodule

bind rline_irq_ctrl irqc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .raster_line(raster_line), .line_start(line_start), .tmr_uf(tmr_uf),
    .irq(irq), .rd_data(rd_data), .flags_q(flags_q), .mask_q(mask_q),
    .cmp_line_q(cmp_line_q)
);

// File: tb/test_rline_irq_ctrl.sv
`timescale 1ns/1ps
module test_rline_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [8:0] raster_line = 9'h000;
    logic       line_start = 1'b0;
    logic [2:0] tmr_uf = 3'b000;
    logic       irq;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_flags = 0, m_mask = 0, m_lo = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    rline_irq_ctrl i_rline_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .raster_line(raster_line), .line_start(line_start), .tmr_uf(tmr_uf),
        .irq(irq), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_read(input int sel);
        case (sel)
            0: return (m_flags | (m_irq << 7) | 'h25) & 'hFF;
            1: return m_mask | 'hA0;
            2: return m_lo;
            default: return 'hFF;
        endcase
    endfunction

    task automatic model_step();
        int old_line, new_line, nmask, nlo, setv, clrv;
        old_line = ((m_mask & 1) << 8) | m_lo;
        nmask = m_mask; nlo = m_lo; setv = 0; clrv = 0;
        if (wr_en) begin
            if (reg_sel == 0) clrv = wr_data;
            else if (reg_sel == 1) nmask = wr_data;
            else if (reg_sel == 2) nlo = wr_data;
        end
        new_line = ((nmask & 1) << 8) | nlo;
        if (new_line != old_line && new_line == int'(raster_line)) setv |= 'h02;
        if (line_start && int'(raster_line) == old_line) setv |= 'h02;
        if (tmr_uf[0]) setv |= 'h08;
        if (tmr_uf[1]) setv |= 'h10;
        if (tmr_uf[2]) setv |= 'h40;
        m_flags = ((m_flags & ~clrv) | setv) & 'h5A;
        m_mask = nmask; m_lo = nlo;
        m_irq = (((m_flags | 4) & m_mask & 'h5E) != 0) ? 1 : 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        check(int'(irq) == m_irq, "R3 irq", int'(irq), m_irq);
        check(int'(rd_data) == exp_read(int'(reg_sel)), "R8 read", int'(rd_data), exp_read(int'(reg_sel)));
        wr_en = 1'b0; line_start = 1'b0; tmr_uf = 3'b000;
    endtask

    task automatic wr(input int sel, input int data);
        reg_sel = 2'(sel); wr_data = 8'(data); wr_en = 1'b1;
        cyc();
    endtask

    task automatic rd_chk(input int sel, input int exp, input string tag);
        reg_sel = 2'(sel);
        #1;
        check(int'(rd_data) == exp, tag, int'(rd_data), exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        cyc();
        rd_chk(0, 'h25, "R1 flags after reset");
        rd_chk(1, 'hA0, "R1 mask after reset");
        rd_chk(2, 'h00, "R1 compare after reset");
        rd_chk(3, 'hFF, "R2 none read");

        tmr_uf = 3'b001; cyc();
        rd_chk(0, 'h2D, "R5 timer0 flag");
        check(irq == 1'b0, "R3 masked no irq", int'(irq), 0);
        wr(1, 'h08);
        check(irq == 1'b1, "R9 mask raises irq", int'(irq), 1);
        rd_chk(0, 'hAD, "R8 summary bit");
        wr(1, 'h00);
        check(irq == 1'b0, "R9 mask drops irq", int'(irq), 0);
        wr(1, 'h08);
        wr(0, 'h08);
        check(irq == 1'b0, "R4 ack drops irq", int'(irq), 0);
        rd_chk(0, 'h25, "R4 flag cleared");

        reg_sel = 2'd0; wr_data = 8'h10; wr_en = 1'b1; tmr_uf = 3'b010; cyc();
        rd_chk(0, 'h35, "R4 set wins over clear");
        tmr_uf = 3'b100; cyc();
        rd_chk(0, 'h75, "R5 timer2 flag");
        wr(0, 'h7F);
        rd_chk(0, 'h25, "R4 clear all");
        wr(1, 'h04);
        check(irq == 1'b1, "R3 mask bit2 forces irq", int'(irq), 1);
        wr(1, 'h00);

        raster_line = 9'h123;
        wr(1, 'h03);
        rd_chk(0, 'h25, "R7 no match yet");
        wr(2, 'h23);
        check(irq == 1'b1, "R7 line write match irq", int'(irq), 1);
        rd_chk(2, 'h23, "R8 compare read");
        wr(0, 'h02);
        wr(2, 'h23);
        rd_chk(0, 'h25, "R7 unchanged line no set");
        line_start = 1'b1; cyc();
        rd_chk(0, 'hA7, "R6 strobe match");
        wr(0, 'h02);
        raster_line = 9'h124;
        line_start = 1'b1; cyc();
        rd_chk(0, 'h25, "R6 strobe mismatch");
        wr(3, 'hFF);
        rd_chk(1, 'hA3, "R2 none write ignored");
        rd_chk(0, 'h25, "R2 none write flags");

        for (int k = 0; k < 400; k++) begin
            raster_line = 9'h120 + 9'($urandom_range(0, 3));
            if ($urandom_range(0, 5) == 0) raster_line[8] = 1'b0;
            line_start = ($urandom_range(0, 3) == 0);
            tmr_uf = 3'($urandom_range(0, 7)) & {3{$urandom_range(0, 2) == 0}};
            reg_sel = 2'($urandom_range(0, 3));
            wr_en = ($urandom_range(0, 2) == 0);
            wr_data = (reg_sel == 2'd2) ? 8'(8'h20 + $urandom_range(0, 3)) : 8'($urandom_range(0, 255));
            cyc();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule